// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block brings a DRAM device from reset to a state where the normal memory controller can use it. After a synchronous reset it walks a fixed, memory-type-specific list of steps. A step either changes the device control lines (reset_n, CKE, ODT) or issues one command with a row address and a bank address. Each step is followed by its own wait. A parameter selects the DDR2 list or the DDR3 list. The mode-register words come in on static input ports, and the block places them into the right steps. For DDR2 it also derives the DLL-reset and OCD variants of those words.

While the list is running, the controller-select output stays low and the command bus carries the sequencer's commands. When the wait after the last step has expired, both the done output and the controller-select output go high. The block then stays idle until the next reset. All waits are counted in controller clock cycles and are set by parameters.

Top module: `dram_powerup_seq`

## Requirements
- R1: While the reset input is high, and in the first cycle after it, the outputs are: dram reset_n low, CKE low, ODT low, all four command pins high (NOP), address and bank zero, done low and controller-select low.
- R2: A command is held internally as a 4-bit word with CS in bit 0, WE in bit 1, CAS in bit 2 and RAS in bit 3, all active-high. Each command pin is the inverse of its bit. A NOP has all four pins high. Precharge-all is word 4'b1011 with address 0x0400. Mode-register load is 4'b1111. Auto-refresh is 4'b1101 with address 0. ZQ calibration is 4'b0011 with address 0x0400.
- R3: A control step has the 4-bit word select=bit0, CKE=bit1, ODT=bit2, reset_n=bit3. It updates reset_n, CKE and ODT from bits 3, 1 and 2, and holds them until the next control step. The command pins show NOP in the cycle a control step takes effect.
- R4: DDR3 step order:
  - reset_n and ODT high with CKE low, then wait T_RESET;
  - CKE, ODT and reset_n high, then wait T_CKE;
  - mode word 2 on bank 2, then mode word 3 on bank 3, then mode word 1 on bank 1, with no waits between them;
  - mode word 0 on bank 0, then wait T_MRS;
  - ZQ calibration on bank 0, then wait T_ZQ.
  
  The mode words are passed through unchanged.
- R5: DDR2 step order:
  - CKE, ODT and reset_n high, then wait T_CKE;
  - precharge-all;
  - mode word 3 on bank 3, then mode word 2 on bank 2, then mode word 1 on bank 1;
  - mode word 0 with DLL reset on bank 0, then wait T_MRS;
  - precharge-all;
  - two auto-refreshes, each followed by a wait of T_REF;
  - mode word 0 without DLL reset, then wait T_MRS;
  - mode word 1 with OCD default;
  - mode word 1 with OCD exit.
  
  The steps with no wait listed have a wait of 0.
- R6: For DDR2, the DLL-reset load carries mode word 0 with bit 8 set, and the later load carries it with bit 8 cleared. The OCD-default load carries mode word 1 with bits 9:7 set to 111, and the OCD-exit load carries it with bits 9:7 cleared. Mode word 0 is built as log2(burst length) in bits 2:0, CAS latency in bits 6:4 and write recovery in bits 11:9.
- R7: The first step takes effect in the first cycle after reset is released. A step with wait D is followed by the next step exactly D+1 cycles later. A wait of 0 means the next step comes in the very next cycle.
- R8: Each command is driven for exactly one cycle. In every cycle with no command step, the pins show NOP.
- R9: Done and controller-select rise together, D+1 cycles after the last step, where D is that step's wait. They stay high until reset. After that no command is issued and the control lines do not change.
- R10: A reset asserted partway through the list returns all outputs to the R1 state. After the reset is released, the list restarts from its first step with the R7 timing.
- R11: CKE is never high while dram reset_n is low, and a command is only issued while CKE is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_w0_i | input | ADDR_W | Static mode word 0 |
| mode_w1_i | input | ADDR_W | Static mode word 1 |
| mode_w2_i | input | ADDR_W | Static mode word 2 |
| mode_w3_i | input | ADDR_W | Static mode word 3 |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_addr_o | output | ADDR_W | Row address of the current command |
| cmd_bank_o | output | BANK_W | Bank address of the current command |
| dram_reset_n_o | output | 1 | Device reset line, active low |
| dram_cke_o | output | 1 | Device clock enable |
| dram_odt_o | output | 1 | Device on-die termination enable |
| init_done_o | output | 1 | High once the sequence has completed |
| ctrl_sel_o | output | 1 | Hands the bus to the normal controller when high |

## Verification
The bench runs a DDR2 instance and a DDR3 instance side by side with short waits. In every cycle it compares the pins against a schedule it computes from the step lists and the rule that a step with wait D is followed D+1 cycles later. If a design is off by one in the wait counter, every later step slides by a cycle. If it mishandles zero-wait steps, the back-to-back mode loads merge or get a gap. The DDR2 mode word 1 is given with bit 7 already set, so a design that ORs instead of clears on OCD exit shows the wrong address. A mid-sequence reset is taken after the DDR3 control lines have risen. A design that does not restart from the first step, or that leaves reset_n or CKE high, then fails the following full run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // memory families the sequencer knows
    typedef enum logic [0:0] {
        MEM_DDR2 = 1'b0,
        MEM_DDR3 = 1'b1
    } mem_kind_e;

    // widths of the step description
    localparam int unsigned STEP_ADDR_BITS = 16;
    localparam int unsigned STEP_BANK_BITS = 3;
    localparam int unsigned STEP_DLY_BITS  = 32;

    // internal command word bit positions (active high)
    localparam int unsigned CB_CS  = 0;
    localparam int unsigned CB_WE  = 1;
    localparam int unsigned CB_CAS = 2;
    localparam int unsigned CB_RAS = 3;

    // control word bit positions
    localparam int unsigned KB_SEL  = 0;
    localparam int unsigned KB_CKE  = 1;
    localparam int unsigned KB_ODT  = 2;
    localparam int unsigned KB_RSTN = 3;

    localparam logic [3:0] CW_PRECHARGE_ALL = 4'b1011;
    localparam logic [3:0] CW_LOAD_MODE     = 4'b1111;
    localparam logic [3:0] CW_REFRESH       = 4'b1101;
    localparam logic [3:0] CW_ZQ_CAL        = 4'b0011;
    localparam logic [3:0] CW_NOP           = 4'b0000;

    localparam logic [3:0] KW_RELEASE_RESET = 4'b1100;
    localparam logic [3:0] KW_CLOCK_ENABLE  = 4'b1110;

    localparam logic [STEP_ADDR_BITS-1:0] A10_SET       = 16'h0400;
    localparam logic [STEP_ADDR_BITS-1:0] DLL_RESET_BIT = 16'h0100;
    localparam logic [STEP_ADDR_BITS-1:0] OCD_FIELD     = 16'h0380;

    localparam int unsigned DDR2_STEPS = 12;
    localparam int unsigned DDR3_STEPS = 7;

    // sequencer phase
    typedef enum logic [1:0] {
        PH_ISSUE = 2'd0,
        PH_WAIT  = 2'd1,
        PH_IDLE  = 2'd2
    } seq_phase_e;

    // one entry of the power-up list
    typedef struct packed {
        logic                      is_ctrl;
        logic [3:0]                word;
        logic [STEP_ADDR_BITS-1:0] addr;
        logic [STEP_BANK_BITS-1:0] bank;
        logic [STEP_DLY_BITS-1:0]  delay;
    } init_step_t;

    function automatic init_step_t step_cmd(
        input logic [3:0]                w,
        input logic [STEP_ADDR_BITS-1:0] a,
        input logic [STEP_BANK_BITS-1:0] b,
        input logic [STEP_DLY_BITS-1:0]  d
    );
        init_step_t s;
        s.is_ctrl = 1'b0;
        s.word    = w;
        s.addr    = a;
        s.bank    = b;
        s.delay   = d;
        return s;
    endfunction

    function automatic init_step_t step_ctrl(
        input logic [3:0]               w,
        input logic [STEP_DLY_BITS-1:0] d
    );
        init_step_t s;
        s.is_ctrl = 1'b1;
        s.word    = w;
        s.addr    = '0;
        s.bank    = '0;
        s.delay   = d;
        return s;
    endfunction

    function automatic init_step_t step_none();
        init_step_t s;
        s = '0;
        return s;
    endfunction

    function automatic int unsigned step_count(input mem_kind_e k);
        return (k == MEM_DDR3) ? DDR3_STEPS : DDR2_STEPS;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_step_rom.sv
module init_step_rom
    import sdram_init_pkg::*;
#(
    parameter mem_kind_e   MEM     = MEM_DDR3,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned T_RESET = 50000,
    parameter int unsigned T_CKE   = 10000,
    parameter int unsigned T_MRS   = 200,
    parameter int unsigned T_ZQ    = 200,
    parameter int unsigned T_REF   = 4
) (
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [STEP_ADDR_BITS-1:0] mw0_i,
    input  logic [STEP_ADDR_BITS-1:0] mw1_i,
    input  logic [STEP_ADDR_BITS-1:0] mw2_i,
    input  logic [STEP_ADDR_BITS-1:0] mw3_i,
    output init_step_t                step_o
);

    localparam logic [STEP_DLY_BITS-1:0] D_RESET = STEP_DLY_BITS'(T_RESET);
    localparam logic [STEP_DLY_BITS-1:0] D_CKE   = STEP_DLY_BITS'(T_CKE);
    localparam logic [STEP_DLY_BITS-1:0] D_MRS   = STEP_DLY_BITS'(T_MRS);
    localparam logic [STEP_DLY_BITS-1:0] D_ZQ    = STEP_DLY_BITS'(T_ZQ);
    localparam logic [STEP_DLY_BITS-1:0] D_REF   = STEP_DLY_BITS'(T_REF);
    localparam logic [STEP_DLY_BITS-1:0] D_NONE  = '0;

    generate
        if (MEM == MEM_DDR3) begin : g_ddr3
            always_comb begin
                case (idx_i)
                    IDX_W'(0): step_o = step_ctrl(KW_RELEASE_RESET, D_RESET);
                    IDX_W'(1): step_o = step_ctrl(KW_CLOCK_ENABLE, D_CKE);
                    IDX_W'(2): step_o = step_cmd(CW_LOAD_MODE, mw2_i, 3'd2, D_NONE);
                    IDX_W'(3): step_o = step_cmd(CW_LOAD_MODE, mw3_i, 3'd3, D_NONE);
                    IDX_W'(4): step_o = step_cmd(CW_LOAD_MODE, mw1_i, 3'd1, D_NONE);
                    IDX_W'(5): step_o = step_cmd(CW_LOAD_MODE, mw0_i, 3'd0, D_MRS);
                    IDX_W'(6): step_o = step_cmd(CW_ZQ_CAL, A10_SET, 3'd0, D_ZQ);
                    default:   step_o = step_none();
                endcase
            end
        end else begin : g_ddr2
            logic [STEP_ADDR_BITS-1:0] mw0_dll_on;
            logic [STEP_ADDR_BITS-1:0] mw0_dll_off;
            logic [STEP_ADDR_BITS-1:0] mw1_ocd_dflt;
            logic [STEP_ADDR_BITS-1:0] mw1_ocd_exit;

            assign mw0_dll_on   = mw0_i | DLL_RESET_BIT;
            assign mw0_dll_off  = mw0_i & ~DLL_RESET_BIT;
            assign mw1_ocd_dflt = mw1_i | OCD_FIELD;
            assign mw1_ocd_exit = mw1_i & ~OCD_FIELD;

            always_comb begin
                case (idx_i)
                    IDX_W'(0):  step_o = step_ctrl(KW_CLOCK_ENABLE, D_CKE);
                    IDX_W'(1):  step_o = step_cmd(CW_PRECHARGE_ALL, A10_SET, 3'd0, D_NONE);
                    IDX_W'(2):  step_o = step_cmd(CW_LOAD_MODE, mw3_i, 3'd3, D_NONE);
                    IDX_W'(3):  step_o = step_cmd(CW_LOAD_MODE, mw2_i, 3'd2, D_NONE);
                    IDX_W'(4):  step_o = step_cmd(CW_LOAD_MODE, mw1_i, 3'd1, D_NONE);
                    IDX_W'(5):  step_o = step_cmd(CW_LOAD_MODE, mw0_dll_on, 3'd0, D_MRS);
                    IDX_W'(6):  step_o = step_cmd(CW_PRECHARGE_ALL, A10_SET, 3'd0, D_NONE);
                    IDX_W'(7):  step_o = step_cmd(CW_REFRESH, '0, 3'd0, D_REF);
                    IDX_W'(8):  step_o = step_cmd(CW_REFRESH, '0, 3'd0, D_REF);
                    IDX_W'(9):  step_o = step_cmd(CW_LOAD_MODE, mw0_dll_off, 3'd0, D_MRS);
                    IDX_W'(10): step_o = step_cmd(CW_LOAD_MODE, mw1_ocd_dflt, 3'd1, D_NONE);
                    IDX_W'(11): step_o = step_cmd(CW_LOAD_MODE, mw1_ocd_exit, 3'd1, D_NONE);
                    default:    step_o = step_none();
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl
    import sdram_init_pkg::*;
#(
    parameter int unsigned NSTEPS = 7,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [STEP_DLY_BITS-1:0] step_delay_i,
    output logic [IDX_W-1:0]         idx_o,
    output logic                     issue_o,
    output logic                     finished_o
);

    localparam logic [IDX_W-1:0] LAST_PLUS_ONE = IDX_W'(NSTEPS);

    seq_phase_e        phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fin_q;
    logic              at_end;

    assign at_end     = (idx_q == LAST_PLUS_ONE);
    assign issue_o    = (phase_q == PH_ISSUE) && !at_end;
    assign idx_o      = idx_q;
    assign finished_o = fin_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_ISSUE;
            idx_q   <= '0;
            cnt_q   <= '0;
            fin_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_ISSUE: begin
                    if (at_end) begin
                        phase_q <= PH_IDLE;
                        fin_q   <= 1'b1;
                    end else if (step_delay_i == '0) begin
                        idx_q <= idx_q + IDX_W'(1);
                    end else begin
                        cnt_q   <= step_delay_i[CNT_W-1:0];
                        phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        idx_q   <= idx_q + IDX_W'(1);
                        phase_q <= PH_ISSUE;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BANK_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              issue_i,
    input  logic              is_ctrl_i,
    input  logic [3:0]        word_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              reset_n_o,
    output logic              cke_o,
    output logic              odt_o
);

    logic [3:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bank_q;
    logic              rstn_q;
    logic              cke_q;
    logic              odt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmd_q  <= CW_NOP;
            addr_q <= '0;
            bank_q <= '0;
            rstn_q <= 1'b0;
            cke_q  <= 1'b0;
            odt_q  <= 1'b0;
        end else begin
            cmd_q  <= CW_NOP;
            addr_q <= '0;
            bank_q <= '0;
            if (issue_i) begin
                if (is_ctrl_i) begin
                    rstn_q <= word_i[KB_RSTN];
                    cke_q  <= word_i[KB_CKE];
                    odt_q  <= word_i[KB_ODT];
                end else begin
                    cmd_q  <= word_i;
                    addr_q <= addr_i;
                    bank_q <= bank_i;
                end
            end
        end
    end

    assign cs_n_o    = ~cmd_q[CB_CS];
    assign we_n_o    = ~cmd_q[CB_WE];
    assign cas_n_o   = ~cmd_q[CB_CAS];
    assign ras_n_o   = ~cmd_q[CB_RAS];
    assign addr_o    = addr_q;
    assign bank_o    = bank_q;
    assign reset_n_o = rstn_q;
    assign cke_o     = cke_q;
    assign odt_o     = odt_q;

endmodule

// File: rtl/dram_powerup_seq.sv
module dram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter mem_kind_e   MEM     = MEM_DDR3,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned BANK_W  = 3,
    parameter int unsigned T_RESET = 50000,
    parameter int unsigned T_CKE   = (MEM == MEM_DDR3) ? 10000 : 20000,
    parameter int unsigned T_MRS   = 200,
    parameter int unsigned T_ZQ    = 200,
    parameter int unsigned T_REF   = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] mode_w0_i,
    input  logic [ADDR_W-1:0] mode_w1_i,
    input  logic [ADDR_W-1:0] mode_w2_i,
    input  logic [ADDR_W-1:0] mode_w3_i,
    output logic              cmd_cs_n_o,
    output logic              cmd_ras_n_o,
    output logic              cmd_cas_n_o,
    output logic              cmd_we_n_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic              dram_reset_n_o,
    output logic              dram_cke_o,
    output logic              dram_odt_o,
    output logic              init_done_o,
    output logic              ctrl_sel_o
);

    localparam int unsigned NSTEPS  = step_count(MEM);
    localparam int unsigned IDX_W   = $clog2(NSTEPS + 1);
    localparam int unsigned MAX_DLY = max_u(max_u(max_u(T_RESET, T_CKE), max_u(T_MRS, T_ZQ)), T_REF);
    localparam int unsigned CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY + 1);

    logic [IDX_W-1:0] idx;
    logic             issue;
    logic             finished;
    init_step_t       step;

    init_step_rom #(
        .MEM     (MEM),
        .IDX_W   (IDX_W),
        .T_RESET (T_RESET),
        .T_CKE   (T_CKE),
        .T_MRS   (T_MRS),
        .T_ZQ    (T_ZQ),
        .T_REF   (T_REF)
    ) i_rom (
        .idx_i  (idx),
        .mw0_i  (STEP_ADDR_BITS'(mode_w0_i)),
        .mw1_i  (STEP_ADDR_BITS'(mode_w1_i)),
        .mw2_i  (STEP_ADDR_BITS'(mode_w2_i)),
        .mw3_i  (STEP_ADDR_BITS'(mode_w3_i)),
        .step_o (step)
    );

    init_seq_ctrl #(
        .NSTEPS (NSTEPS),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) i_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .step_delay_i (step.delay),
        .idx_o        (idx),
        .issue_o      (issue),
        .finished_o   (finished)
    );

    init_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) i_drive (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .issue_i   (issue),
        .is_ctrl_i (step.is_ctrl),
        .word_i    (step.word),
        .addr_i    (step.addr[ADDR_W-1:0]),
        .bank_i    (step.bank[BANK_W-1:0]),
        .cs_n_o    (cmd_cs_n_o),
        .ras_n_o   (cmd_ras_n_o),
        .cas_n_o   (cmd_cas_n_o),
        .we_n_o    (cmd_we_n_o),
        .addr_o    (cmd_addr_o),
        .bank_o    (cmd_bank_o),
        .reset_n_o (dram_reset_n_o),
        .cke_o     (dram_cke_o),
        .odt_o     (dram_odt_o)
    );

    assign init_done_o = finished;
    assign ctrl_sel_o  = finished;

endmodule

// File: rtl/dram_powerup_seq_chk.sv
module dram_powerup_seq_chk (
    input logic clk_i,
    input logic rst_i,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic reset_n,
    input logic cke,
    input logic odt,
    input logic done
);

    // R2: a deselected bus always shows the full NOP pattern
    a_r2_nop_all_high: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n |-> (ras_n && cas_n && we_n));

    // R3: a control-line step never coincides with a command
    a_r3_ctrl_edge_no_cmd: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(cke) || $rose(reset_n)) |-> cs_n);

    // R9: completion is sticky
    a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        done |=> done);

    // R9: nothing is issued once done
    a_r9_idle_after_done: assert property (@(posedge clk_i) disable iff (rst_i)
        done |-> cs_n);

    // R9: control lines frozen after completion
    a_r9_lines_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        done |=> ($stable(reset_n) && $stable(cke) && $stable(odt)));

    // R11: clock enable only after the device reset is released
    a_r11_cke_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        cke |-> reset_n);

    // R11: commands only while clock enable is high
    a_r11_cmd_needs_cke: assert property (@(posedge clk_i) disable iff (rst_i)
        !cs_n |-> cke);

endmodule

bind dram_powerup_seq dram_powerup_seq_chk i_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cs_n    (cmd_cs_n_o),
    .ras_n   (cmd_ras_n_o),
    .cas_n   (cmd_cas_n_o),
    .we_n    (cmd_we_n_o),
    .reset_n (dram_reset_n_o),
    .cke     (dram_cke_o),
    .odt     (dram_odt_o),
    .done    (init_done_o)
);

// File: tb/test_dram_powerup_seq.sv
module test_dram_powerup_seq;
    import sdram_init_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int P_RESET = 60;
    localparam int P_CKE   = 40;
    localparam int P_MRS   = 20;
    localparam int P_ZQ    = 16;
    localparam int P_REF   = 4;
    localparam int RUN_LEN = 170;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // DDR2 mode words: word 0 = log2(BL=4) | CL=5 << 4 | WR=2 << 9
    localparam logic [15:0] D2_W0 = 16'(2 | (5 << 4) | (2 << 9));
    localparam logic [15:0] D2_W1 = 16'h00C4;
    localparam logic [15:0] D2_W2 = 16'h0008;
    localparam logic [15:0] D2_W3 = 16'h0010;
    localparam logic [15:0] D3_W0 = 16'h1520;
    localparam logic [15:0] D3_W1 = 16'h0046;
    localparam logic [15:0] D3_W2 = 16'h0218;
    localparam logic [15:0] D3_W3 = 16'h0004;

    logic        cs3, ras3, cas3, we3, rn3, ck3, od3, dn3, sl3;
    logic [15:0] a3;
    logic [2:0]  b3;
    logic        cs2, ras2, cas2, we2, rn2, ck2, od2, dn2, sl2;
    logic [15:0] a2;
    logic [2:0]  b2;

    dram_powerup_seq #(
        .MEM(MEM_DDR3), .ADDR_W(16), .BANK_W(3), .T_RESET(P_RESET), .T_CKE(P_CKE),
        .T_MRS(P_MRS), .T_ZQ(P_ZQ), .T_REF(P_REF)
    ) i_dram_powerup_seq (
        .clk_i(clk), .rst_i(rst),
        .mode_w0_i(D3_W0), .mode_w1_i(D3_W1), .mode_w2_i(D3_W2), .mode_w3_i(D3_W3),
        .cmd_cs_n_o(cs3), .cmd_ras_n_o(ras3), .cmd_cas_n_o(cas3), .cmd_we_n_o(we3),
        .cmd_addr_o(a3), .cmd_bank_o(b3), .dram_reset_n_o(rn3), .dram_cke_o(ck3),
        .dram_odt_o(od3), .init_done_o(dn3), .ctrl_sel_o(sl3)
    );

    dram_powerup_seq #(
        .MEM(MEM_DDR2), .ADDR_W(16), .BANK_W(3), .T_RESET(P_RESET), .T_CKE(P_CKE),
        .T_MRS(P_MRS), .T_ZQ(P_ZQ), .T_REF(P_REF)
    ) i_dram_powerup_seq_ddr2 (
        .clk_i(clk), .rst_i(rst),
        .mode_w0_i(D2_W0), .mode_w1_i(D2_W1), .mode_w2_i(D2_W2), .mode_w3_i(D2_W3),
        .cmd_cs_n_o(cs2), .cmd_ras_n_o(ras2), .cmd_cas_n_o(cas2), .cmd_we_n_o(we2),
        .cmd_addr_o(a2), .cmd_bank_o(b2), .dram_reset_n_o(rn2), .dram_cke_o(ck2),
        .dram_odt_o(od2), .init_done_o(dn2), .ctrl_sel_o(sl2)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    // expected schedule, index 0 = DDR2, 1 = DDR3
    int   n_steps  [2];
    bit   e_ctl    [2][12];
    int   e_word   [2][12];
    int   e_addr   [2][12];
    int   e_bank   [2][12];
    int   e_dly    [2][12];
    int   e_t      [2][12];
    int   e_done   [2];
    int   cur_ctl  [2];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic put(input int m, input int k, input bit c, input int w, input int a, input int b, input int d);
        e_ctl[m][k] = c; e_word[m][k] = w; e_addr[m][k] = a; e_bank[m][k] = b; e_dly[m][k] = d;
    endtask

    task automatic build;
        // DDR2 (R5, R6)
        n_steps[0] = 12;
        put(0, 0, 1, 'hE, 0, 0, P_CKE);
        put(0, 1, 0, 'hB, 'h400, 0, 0);
        put(0, 2, 0, 'hF, D2_W3, 3, 0);
        put(0, 3, 0, 'hF, D2_W2, 2, 0);
        put(0, 4, 0, 'hF, D2_W1, 1, 0);
        put(0, 5, 0, 'hF, D2_W0 | 'h100, 0, P_MRS);
        put(0, 6, 0, 'hB, 'h400, 0, 0);
        put(0, 7, 0, 'hD, 0, 0, P_REF);
        put(0, 8, 0, 'hD, 0, 0, P_REF);
        put(0, 9, 0, 'hF, D2_W0 & ~'h100, 0, P_MRS);
        put(0, 10, 0, 'hF, D2_W1 | 'h380, 1, 0);
        put(0, 11, 0, 'hF, D2_W1 & ~'h380, 1, 0);
        // DDR3 (R4)
        n_steps[1] = 7;
        put(1, 0, 1, 'hC, 0, 0, P_RESET);
        put(1, 1, 1, 'hE, 0, 0, P_CKE);
        put(1, 2, 0, 'hF, D3_W2, 2, 0);
        put(1, 3, 0, 'hF, D3_W3, 3, 0);
        put(1, 4, 0, 'hF, D3_W1, 1, 0);
        put(1, 5, 0, 'hF, D3_W0, 0, P_MRS);
        put(1, 6, 0, 'h3, 'h400, 0, P_ZQ);
        // R7 timing: first step in cycle 1, then D+1 apart
        for (int m = 0; m < 2; m++) begin
            e_t[m][0] = 1;
            for (int k = 1; k < n_steps[m]; k++) e_t[m][k] = e_t[m][k-1] + e_dly[m][k-1] + 1;
            e_done[m] = e_t[m][n_steps[m]-1] + e_dly[m][n_steps[m]-1] + 1;
        end
    endtask

    task automatic check_cycle(input int m, input logic csn, input logic rasn, input logic casn,
                               input logic wen, input logic [15:0] a, input logic [2:0] b,
                               input logic rn, input logic ck, input logic od,
                               input logic dn, input logic sl);
        int k;
        string tg;
        int w;
        bit exp_done;
        k = -1;
        tg = (m == 1) ? "R4" : "R5";
        for (int s = 0; s < n_steps[m]; s++) if (e_t[m][s] == cyc) k = s;
        if (k >= 0 && e_ctl[m][k]) cur_ctl[m] = e_word[m][k];
        if (k >= 0 && !e_ctl[m][k]) begin
            w = e_word[m][k];
            chk({rasn, casn, wen, csn} == ~4'(w), "R2", {tg, " command pins (ras,cas,we,cs)"},
                {rasn, casn, wen, csn}, ~4'(w) & 'hF);
            chk(a == 16'(e_addr[m][k]), (m == 0 && (k == 5 || k >= 9)) ? "R6" : tg,
                $sformatf("address step %0d", k), a, e_addr[m][k]);
            chk(b == 3'(e_bank[m][k]), tg, $sformatf("bank step %0d", k), b, e_bank[m][k]);
        end else begin
            chk({rasn, casn, wen, csn} == 4'hF, "R8", "R7 NOP expected (R3 on control steps)",
                {rasn, casn, wen, csn}, 'hF);
        end
        chk({rn, od, ck} == {cur_ctl[m][3], cur_ctl[m][2], cur_ctl[m][1]}, "R3",
            {tg, " control lines (reset_n,odt,cke)"}, {rn, od, ck},
            {cur_ctl[m][3], cur_ctl[m][2], cur_ctl[m][1]});
        exp_done = (cyc >= e_done[m]);
        chk(dn == exp_done && sl == exp_done, "R9", {tg, " done/select"}, {dn, sl}, {exp_done, exp_done});
    endtask

    task automatic check_reset_state(input string tg);
        chk({rn3, ck3, od3, dn3, sl3} == 5'b0 && {cs3, ras3, cas3, we3} == 4'hF && a3 == 0 && b3 == 0,
            tg, "DDR3 reset state", {rn3, ck3, od3, dn3, sl3, cs3, ras3, cas3, we3}, 'h0F);
        chk({rn2, ck2, od2, dn2, sl2} == 5'b0 && {cs2, ras2, cas2, we2} == 4'hF && a2 == 0 && b2 == 0,
            tg, "DDR2 reset state", {rn2, ck2, od2, dn2, sl2, cs2, ras2, cas2, we2}, 'h0F);
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check_cycle(1, cs3, ras3, cas3, we3, a3, b3, rn3, ck3, od3, dn3, sl3);
            check_cycle(0, cs2, ras2, cas2, we2, a2, b2, rn2, ck2, od2, dn2, sl2);
        end
    end

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        build();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        // first full run from power-on
        cur_ctl[0] = 0; cur_ctl[1] = 0;
        rst = 1'b0;
        chk_en = 1'b1;
        repeat (RUN_LEN) @(negedge clk);
        chk_en = 1'b0;
        // partial run, then reset partway (R10)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (90) @(negedge clk);
        chk(rn3 && ck3 && !dn3, "R10", "DDR3 lines raised before mid reset", {rn3, ck3, dn3}, 'b110);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state("R10");
        // second full run must restart from the first step
        cur_ctl[0] = 0; cur_ctl[1] = 0;
        rst = 1'b0;
        chk_en = 1'b1;
        repeat (RUN_LEN) @(negedge clk);
        chk_en = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule